// File: doc/BRIEF.md
# Bus Halt Sequencing Controller

This block sits between a bus master's cycle engine and the external bus pins. It decides when an external halt request may freeze the bus. A halt is honoured only at the end of a whole operand. While the bus is frozen, the block drives the pin groups in a defined way:

- the data bus is released to high impedance;
- both strobes are held inactive;
- the address, function-code, size and read/write pins keep their last driven values.

The halt request is asynchronous, so it passes through a two-flop synchroniser first. A bus error that arrives while a halt is pending does not raise an exception. Instead it freezes the bus and records a retry, and the block issues that retry when the halt is released.

The cycle engine is outside this block. It reports three things: a cycle in progress, the end of a cycle, and how many byte cycles of the current operand are still to come after this one. The engine treats `halted` as its hold line. Interrupt acceptance is permitted only while the bus is running.

Top module: `bus_halt_seq`

## Requirements
- R1: `halt_in` passes through two flops. A change of `halt_in` set up before clock edge 1 is first acted on at clock edge 3.
- R2: During an active cycle, the synchronised halt takes effect at the edge where `cyc_done` is high and `bytes_left` is 0. If `bytes_left` is non-zero, the bus keeps running. With no cycle active, the halt takes effect at the next edge.
- R3: While halted, `data_oe` is 0. While running, `data_oe` equals `eng_active` AND NOT `eng_rw` (`eng_rw` = 1 means read).
- R4: While halted, `as_n` and `ds_n` are 1. While running with `eng_active` = 1, both are 0.
- R5: While halted, `addr_o`, `fc_o`, `size_o` and `rw_o` keep the values of the last active cycle, whatever the engine presents. While running with a cycle active, these pins follow the engine's values. With no cycle active, they show the last latched values.
- R6: A bus error during an active cycle while the synchronised halt is high has two effects. The bus halts at that edge, whatever `bytes_left` is. `berr_exc` stays 0.
- R7: A bus error during an active cycle with the synchronised halt low raises `berr_exc` for exactly one cycle after the edge. A bus error while halted is ignored.
- R8: `irq_ok` is 0 while halted and 1 while running.
- R9: Release happens at the first edge where the synchronised halt is low in the halted state. At that edge the bus returns to running. `retry` pulses for one cycle if a retry is pending, and does not pulse otherwise.
- R10: After reset, the outputs take these values:
  - `halted`, `retry`, `berr_exc` and `data_oe` are 0;
  - both strobes are 1;
  - `irq_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_in | input | 1 | Asynchronous halt request, active high |
| eng_active | input | 1 | Cycle engine has a bus cycle in progress |
| eng_addr | input | ADDR_W | Address from the engine |
| eng_fc | input | FC_W | Function code from the engine |
| eng_size | input | SIZE_W | Transfer size from the engine |
| eng_rw | input | 1 | 1 = read, 0 = write |
| eng_wdata | input | DATA_W | Write data from the engine |
| cyc_done | input | 1 | Current bus cycle completes this clock |
| bus_err | input | 1 | Current bus cycle ends with a bus error |
| bytes_left | input | CNT_W | Byte cycles of the operand remaining after this one |
| addr_o | output | ADDR_W | Address pins |
| fc_o | output | FC_W | Function-code pins |
| size_o | output | SIZE_W | Size pins |
| rw_o | output | 1 | Read/write pin |
| data_o | output | DATA_W | Data pins (output value) |
| data_oe | output | 1 | Data pin output enable |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| halted | output | 1 | Bus frozen; hold line to the engine |
| retry | output | 1 | One-cycle retry request on release |
| berr_exc | output | 1 | One-cycle bus-error exception |
| irq_ok | output | 1 | Interrupt acceptance permitted |

## Verification
The halt request is applied in three situations:

- **Idle bus.** This isolates the synchroniser latency.
- **Cycle with a non-zero then a zero remaining-byte count.** This separates "stop at the cycle end" from "stop at the operand end".
- **Cycle ended by a bus error.** This separates a retry from an exception.

Separately, a table of running-state vectors alternates read, write and idle cycles, showing the strobe and data-enable decoding. While halted, the engine's address, function code and direction are changed, to show that the pins hold rather than follow. A bus error is injected both while halted and with no halt pending, which tells the ignored case from the exception case.

// File: rtl/bus_halt_seq.sv
module bus_halt_seq #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int FC_W   = 3,
  parameter int SIZE_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_in,
  input  logic              eng_active,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [FC_W-1:0]   eng_fc,
  input  logic [SIZE_W-1:0] eng_size,
  input  logic              eng_rw,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              cyc_done,
  input  logic              bus_err,
  input  logic [CNT_W-1:0]  bytes_left,
  output logic [ADDR_W-1:0] addr_o,
  output logic [FC_W-1:0]   fc_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              rw_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              as_n,
  output logic              ds_n,
  output logic              halted,
  output logic              retry,
  output logic              berr_exc,
  output logic              irq_ok
);

  logic              sync1, sync2;
  logic              halted_q, retry_pend, retry_q, berr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [FC_W-1:0]   fc_q;
  logic [SIZE_W-1:0] size_q;
  logic              rw_q;
  logic [DATA_W-1:0] data_q;

  wire live    = !halted_q && eng_active;
  wire op_end  = cyc_done && (bytes_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1      <= 1'b0;
      sync2      <= 1'b0;
      halted_q   <= 1'b0;
      retry_pend <= 1'b0;
      retry_q    <= 1'b0;
      berr_q     <= 1'b0;
      addr_q     <= '0;
      fc_q       <= '0;
      size_q     <= '0;
      rw_q       <= 1'b1;
      data_q     <= '0;
    end else begin
      sync1   <= halt_in;
      sync2   <= sync1;
      retry_q <= 1'b0;
      berr_q  <= 1'b0;
      if (!halted_q) begin
        if (eng_active) begin
          addr_q <= eng_addr;
          fc_q   <= eng_fc;
          size_q <= eng_size;
          rw_q   <= eng_rw;
          data_q <= eng_wdata;
          if (bus_err) begin
            if (sync2) begin
              halted_q   <= 1'b1;
              retry_pend <= 1'b1;
            end else begin
              berr_q <= 1'b1;
            end
          end else if (sync2 && op_end) begin
            halted_q <= 1'b1;
          end
        end else if (sync2) begin
          halted_q <= 1'b1;
        end
      end else if (!sync2) begin
        halted_q   <= 1'b0;
        retry_q    <= retry_pend;
        retry_pend <= 1'b0;
      end
    end
  end

  assign addr_o   = live ? eng_addr  : addr_q;
  assign fc_o     = live ? eng_fc    : fc_q;
  assign size_o   = live ? eng_size  : size_q;
  assign rw_o     = live ? eng_rw    : rw_q;
  assign data_o   = live ? eng_wdata : data_q;
  assign data_oe  = live && !eng_rw;
  assign as_n     = !live;
  assign ds_n     = !live;
  assign halted   = halted_q;
  assign retry    = retry_q;
  assign berr_exc = berr_q;
  assign irq_ok   = !halted_q;

  p_data_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !data_oe);

  p_strobes_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (as_n && ds_n));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |->
      ($stable(addr_o) && $stable(fc_o) && $stable(size_o) && $stable(rw_o)));

  p_no_exc_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !berr_exc);

  p_exc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    berr_exc |=> !berr_exc);

  p_irq_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !irq_ok);

  p_retry_on_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> (!halted && $fell(halted)));

endmodule

// File: tb/bus_halt_seq_test.sv
`timescale 1ns/1ps
module bus_halt_seq_test;
  localparam int ADDR_W = 24, DATA_W = 16, FC_W = 3, SIZE_W = 2, CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n, halt_in, eng_active, eng_rw, cyc_done, bus_err;
  logic [ADDR_W-1:0] eng_addr;
  logic [FC_W-1:0]   eng_fc;
  logic [SIZE_W-1:0] eng_size;
  logic [DATA_W-1:0] eng_wdata;
  logic [CNT_W-1:0]  bytes_left;
  logic [ADDR_W-1:0] addr_o;
  logic [FC_W-1:0]   fc_o;
  logic [SIZE_W-1:0] size_o;
  logic              rw_o, data_oe, as_n, ds_n, halted, retry, berr_exc, irq_ok;
  logic [DATA_W-1:0] data_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bus_halt_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FC_W(FC_W),
                 .SIZE_W(SIZE_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .halt_in(halt_in), .eng_active(eng_active),
    .eng_addr(eng_addr), .eng_fc(eng_fc), .eng_size(eng_size), .eng_rw(eng_rw),
    .eng_wdata(eng_wdata), .cyc_done(cyc_done), .bus_err(bus_err),
    .bytes_left(bytes_left), .addr_o(addr_o), .fc_o(fc_o), .size_o(size_o),
    .rw_o(rw_o), .data_o(data_o), .data_oe(data_oe), .as_n(as_n), .ds_n(ds_n),
    .halted(halted), .retry(retry), .berr_exc(berr_exc), .irq_ok(irq_ok));

  // {active, rw, addr, exp_as_n, exp_data_oe, exp_addr_o}
  localparam logic [1+1+24+1+1+24-1:0] VEC [4] = '{
    {1'b1, 1'b0, 24'h000100, 1'b0, 1'b1, 24'h000100},
    {1'b1, 1'b1, 24'h123456, 1'b0, 1'b0, 24'h123456},
    {1'b0, 1'b0, 24'h00ABCD, 1'b1, 1'b0, 24'h123456},
    {1'b1, 1'b0, 24'hFFFFFE, 1'b0, 1'b1, 24'hFFFFFE}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; halt_in = 0; eng_active = 0; eng_rw = 1; cyc_done = 0; bus_err = 0;
    eng_addr = '0; eng_fc = '0; eng_size = '0; eng_wdata = '0; bytes_left = '0;
    adv(3);
    rst_n = 1;
    adv(1);
    check("R10 halted", halted, 0);
    check("R10 retry", retry, 0);
    check("R10 berr_exc", berr_exc, 0);
    check("R10 as_n", as_n, 1);
    check("R10 ds_n", ds_n, 1);
    check("R10 data_oe", data_oe, 0);
    check("R10 irq_ok", irq_ok, 1);

    for (int i = 0; i < 4; i++) begin
      {eng_active, eng_rw, eng_addr} = VEC[i][51:26];
      #1;
      check("R4 as_n run", as_n, VEC[i][25]);
      check("R4 ds_n run", ds_n, VEC[i][25]);
      check("R3 data_oe run", data_oe, VEC[i][24]);
      check("R5 addr_o run", addr_o, VEC[i][23:0]);
      check("R8 irq_ok run", irq_ok, 1);
      adv(1);
    end

    // R1 / R2 idle halt latency
    eng_active = 0; halt_in = 1;
    adv(2);
    check("R1 not yet halted", halted, 0);
    adv(1);
    check("R1 R2 halted idle", halted, 1);
    halt_in = 0;
    adv(2);
    check("R1 release latency", halted, 1);
    adv(1);
    check("R9 released", halted, 0);
    check("R9 no retry", retry, 0);

    // R2 operand boundary
    eng_active = 1; eng_rw = 0; eng_addr = 24'h0A0A0A; eng_fc = 3'd5; eng_size = 2'd1;
    eng_wdata = 16'h55AA; bytes_left = 3'd1; cyc_done = 0; halt_in = 1;
    adv(3);
    check("R2 no halt mid cycle", halted, 0);
    cyc_done = 1;
    adv(1);
    check("R2 no halt bytes left", halted, 0);
    bytes_left = 3'd0;
    adv(1);
    check("R2 halt at operand end", halted, 1);
    cyc_done = 0; eng_addr = 24'h0B0B0B; eng_fc = 3'd2; eng_rw = 1;
    #1;
    check("R5 addr held", addr_o, 24'h0A0A0A);
    check("R5 fc held", fc_o, 5);
    check("R5 rw held", rw_o, 0);
    check("R4 as_n halted", as_n, 1);
    check("R4 ds_n halted", ds_n, 1);
    check("R3 data_oe halted", data_oe, 0);
    check("R8 irq_ok halted", irq_ok, 0);
    bus_err = 1;
    adv(1);
    check("R7 berr ignored halted", berr_exc, 0);
    bus_err = 0; halt_in = 0;
    adv(3);
    check("R9 released", halted, 0);
    check("R9 no retry pending", retry, 0);
    check("R5 addr live", addr_o, 24'h0B0B0B);

    // R6 retry
    eng_addr = 24'h0C0C0C; bytes_left = 3'd3; halt_in = 1;
    adv(3);
    check("R6 running before error", halted, 0);
    bus_err = 1;
    adv(1);
    check("R6 halted on error", halted, 1);
    check("R6 no exception", berr_exc, 0);
    bus_err = 0; halt_in = 0;
    adv(2);
    check("R9 still halted", halted, 1);
    check("R9 no early retry", retry, 0);
    adv(1);
    check("R9 released", halted, 0);
    check("R6 retry pulse", retry, 1);
    adv(1);
    check("R9 retry one cycle", retry, 0);

    // R7 exception without halt
    bus_err = 1;
    adv(1);
    check("R7 exception", berr_exc, 1);
    check("R7 not halted", halted, 0);
    bus_err = 0;
    adv(1);
    check("R7 exception one cycle", berr_exc, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule